// File: doc/BRIEF.md
# Branch Misprediction Recovery Controller

This block restores the front end of a speculative pipeline when a branch resolves against its prediction. A small allocator hands one speculation tag to each branch as it is fetched. Every instruction that enters the decode buffer, the dispatch buffer or the reservation-station array after that branch is marked speculative and stamped with the tag. The block keeps a valid bit, a speculative flag and a tag for every entry of the three structures.

When the resolution port reports the outstanding branch, the block registers the outcome. In the next cycle it either does nothing or performs a recovery. A correct prediction leaves every entry in place, marks the entries that carry the tag as no longer speculative, and releases the tag. A wrong prediction pulses a fetch redirect and, in that same cycle, a kill vector for each structure. Every entry that holds the tag is dropped in one step, including one that is written in that same cycle. Only one branch may be outstanding, so a second branch at fetch is held off until the first one has been handled.

Top module: `brRecoveryCtl`

## Requirements
- R1: A branch predicted not-taken (resPredTaken=0) that resolves taken (resActTaken=1) drives redirectPc to resTarget.
- R2: A branch predicted taken that resolves not-taken drives redirectPc to resPc + 4.
- R3: For a mispredicted branch, redirectValid and the kill vectors are high for exactly one cycle, the cycle after the accepted resolution, and at no other time.
- R4: In that cycle, bit i of decKill, dspKill or rsKill is set exactly when entry i of that structure is valid, speculative and tagged with the mispredicted branch's tag. Killed entries read as not valid from the next cycle on, and all other entries keep their state.
- R5: An allocation made in the recovery cycle with the speculative flag set and the squashed tag is flagged in the kill vector and does not become valid.
- R6: For a correctly predicted branch there is no redirect and no kill. Entries that carry its tag become non-speculative, so a later misprediction that reuses the same tag value leaves them valid.
- R7: brFetchGrant follows brFetchReq whenever no branch is outstanding, and it returns brFetchTag. The tags are handed out in order 0, 1, 2, ... after reset and wrap modulo 2^TAG_W.
- R8: A branch is outstanding from the cycle after its grant through the cycle of its redirect or release pulse. While it is outstanding, brFetchReq raises allocStall and produces no grant. A grant is possible again in the cycle after the pulse.
- R9: A resolution is ignored, with no redirect, no kill and no release, when no branch is outstanding, when its tag differs from the outstanding tag, or when it arrives in the pulse cycle of the outstanding branch.
- R10: After reset no entry is valid, no redirect or kill is asserted, and the first tag granted is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| brFetchReq | input | 1 | A branch at fetch requests a tag |
| brFetchGrant | output | 1 | Tag granted this cycle |
| brFetchTag | output | TAG_W | Tag handed to the fetched branch |
| allocStall | output | 1 | Request held off: a branch is outstanding |
| resValid | input | 1 | Branch resolution present |
| resTag | input | TAG_W | Tag of the resolving branch |
| resPredTaken | input | 1 | Predicted direction, 1 = taken |
| resActTaken | input | 1 | Actual direction, 1 = taken |
| resTarget | input | PC_W | Computed taken target |
| resPc | input | PC_W | Address of the branch |
| redirectValid | output | 1 | Fetch redirect pulse |
| redirectPc | output | PC_W | Address fetch restarts from |
| decAllocValid | input | 1 | Write a decode-buffer entry |
| decAllocIdx | input | clog2(DEC_N) | Decode entry written |
| decAllocSpec | input | 1 | Entry follows an unresolved branch |
| decAllocTag | input | TAG_W | Tag stamped on the entry |
| decFreeValid | input | 1 | Normal release of a decode entry |
| decFreeIdx | input | clog2(DEC_N) | Decode entry released |
| decValid | output | DEC_N | Decode entry valid bits |
| decKill | output | DEC_N | Decode entries squashed this cycle |
| dspAllocValid | input | 1 | Write a dispatch-buffer entry |
| dspAllocIdx | input | clog2(DSP_N) | Dispatch entry written |
| dspAllocSpec | input | 1 | Entry follows an unresolved branch |
| dspAllocTag | input | TAG_W | Tag stamped on the entry |
| dspFreeValid | input | 1 | Normal release of a dispatch entry |
| dspFreeIdx | input | clog2(DSP_N) | Dispatch entry released |
| dspValid | output | DSP_N | Dispatch entry valid bits |
| dspKill | output | DSP_N | Dispatch entries squashed this cycle |
| rsAllocValid | input | 1 | Write a reservation-station entry |
| rsAllocIdx | input | clog2(RS_N) | Station entry written |
| rsAllocSpec | input | 1 | Entry follows an unresolved branch |
| rsAllocTag | input | TAG_W | Tag stamped on the entry |
| rsFreeValid | input | 1 | Normal release (issue) of a station entry |
| rsFreeIdx | input | clog2(RS_N) | Station entry released |
| rsValid | output | RS_N | Station entry valid bits |
| rsKill | output | RS_N | Station entries squashed this cycle |

## Verification
The properties assume that a resolution reports a branch whose prediction is known in the cycle it arrives. They also assume that an allocation never targets the index freed in the same cycle and never targets an entry that is already valid. The random stimulus keeps to these rules: it drops a free that collides with an allocation, and it allocates only into entries that its own model holds as empty. Resolutions are aimed mostly at the outstanding tag, but some carry stray tags or arrive while no branch is outstanding. Directed sequences cover redirects in both directions, an allocation in the recovery cycle, and a full wrap of the tag space, so that a committed tag value is reused in a later misprediction.

// File: rtl/brRecPkg.sv
package brRecPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture; // accepted resolution this cycle: latch target and tag
    logic squash;  // recovery cycle: redirect and kill
    logic commit;  // correct prediction: clear speculative marks
  } recStrobe_t;
endpackage

// File: rtl/brRecCtl.sv
module brRecCtl
  import brRecPkg::*;
#(
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             brFetchReq,
  output logic             brFetchGrant,
  output logic [TAG_W-1:0] brFetchTag,
  output logic             allocStall,
  input  logic             resValid,
  input  logic [TAG_W-1:0] resTag,
  input  logic             resPredTaken,
  input  logic             resActTaken,
  output recStrobe_t       strobe
);
  logic             outst_q;
  logic             pend_q;
  logic             pendMiss_q;
  logic [TAG_W-1:0] curTag_q;
  logic [TAG_W-1:0] nextTag_q;
  logic             grant;
  logic             resHit;

  always_comb begin
    grant          = brFetchReq && !outst_q;
    resHit         = resValid && outst_q && !pend_q && (resTag == curTag_q);
    strobe.capture = resHit;
    strobe.squash  = pend_q && pendMiss_q;
    strobe.commit  = pend_q && !pendMiss_q;
  end

  assign brFetchGrant = grant;
  assign brFetchTag   = nextTag_q;
  assign allocStall   = brFetchReq && outst_q;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outst_q    <= 1'b0;
      pend_q     <= 1'b0;
      pendMiss_q <= 1'b0;
      curTag_q   <= '0;
      nextTag_q  <= '0;
    end else begin
      pend_q <= resHit;
      if (resHit) pendMiss_q <= resPredTaken ^ resActTaken;
      if (pend_q) begin
        outst_q <= 1'b0;
      end else if (grant) begin
        outst_q   <= 1'b1;
        curTag_q  <= nextTag_q;
        nextTag_q <= nextTag_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/specTagBuf.sv
module specTagBuf #(
  parameter int N     = 4,
  parameter int TAG_W = 2,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic [IDX_W-1:0] allocIdx,
  input  logic             allocSpec,
  input  logic [TAG_W-1:0] allocTag,
  input  logic             freeValid,
  input  logic [IDX_W-1:0] freeIdx,
  input  logic             squash,
  input  logic             commit,
  input  logic [TAG_W-1:0] evTag,
  output logic [N-1:0]     validVec,
  output logic [N-1:0]     killVec
);
  logic [N-1:0]     valid_q;
  logic [N-1:0]     spec_q;
  logic [N-1:0]     validN;
  logic [N-1:0]     specN;
  logic [TAG_W-1:0] tagN  [N];
  logic [TAG_W-1:0] tag_q [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic hitAlloc;
      hitAlloc   = allocValid && (allocIdx == IDX_W'(i));
      killVec[i] = squash &&
                   ((valid_q[i] && spec_q[i] && (tag_q[i] == evTag)) ||
                    (hitAlloc && allocSpec && (allocTag == evTag)));
      validN[i] = valid_q[i];
      specN[i]  = spec_q[i];
      tagN[i]   = tag_q[i];
      if (freeValid && (freeIdx == IDX_W'(i))) validN[i] = 1'b0;
      if (hitAlloc) begin
        validN[i] = 1'b1;
        specN[i]  = allocSpec;
        tagN[i]   = allocTag;
      end
      if (killVec[i]) validN[i] = 1'b0;
      if (commit && (tagN[i] == evTag)) specN[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid_q <= '0;
      spec_q  <= '0;
    end else begin
      valid_q <= validN;
      spec_q  <= specN;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_tag
    always_ff @(posedge clk) begin
      if (!rstN) tag_q[g] <= '0;
      else       tag_q[g] <= tagN[g];
    end
  end

  assign validVec = valid_q;
endmodule

// File: rtl/brRecData.sv
module brRecData
  import brRecPkg::*;
#(
  parameter int TAG_W = 2,
  parameter int PC_W  = 32,
  parameter int DEC_N = 4,
  parameter int DSP_N = 4,
  parameter int RS_N  = 8,
  localparam int DEC_IW = (DEC_N > 1) ? $clog2(DEC_N) : 1,
  localparam int DSP_IW = (DSP_N > 1) ? $clog2(DSP_N) : 1,
  localparam int RS_IW  = (RS_N > 1) ? $clog2(RS_N) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  recStrobe_t        strobe,
  input  logic [TAG_W-1:0]  resTag,
  input  logic              resActTaken,
  input  logic [PC_W-1:0]   resTarget,
  input  logic [PC_W-1:0]   resPc,
  output logic              redirectValid,
  output logic [PC_W-1:0]   redirectPc,
  input  logic              decAllocValid,
  input  logic [DEC_IW-1:0] decAllocIdx,
  input  logic              decAllocSpec,
  input  logic [TAG_W-1:0]  decAllocTag,
  input  logic              decFreeValid,
  input  logic [DEC_IW-1:0] decFreeIdx,
  output logic [DEC_N-1:0]  decValid,
  output logic [DEC_N-1:0]  decKill,
  input  logic              dspAllocValid,
  input  logic [DSP_IW-1:0] dspAllocIdx,
  input  logic              dspAllocSpec,
  input  logic [TAG_W-1:0]  dspAllocTag,
  input  logic              dspFreeValid,
  input  logic [DSP_IW-1:0] dspFreeIdx,
  output logic [DSP_N-1:0]  dspValid,
  output logic [DSP_N-1:0]  dspKill,
  input  logic              rsAllocValid,
  input  logic [RS_IW-1:0]  rsAllocIdx,
  input  logic              rsAllocSpec,
  input  logic [TAG_W-1:0]  rsAllocTag,
  input  logic              rsFreeValid,
  input  logic [RS_IW-1:0]  rsFreeIdx,
  output logic [RS_N-1:0]   rsValid,
  output logic [RS_N-1:0]   rsKill
);
  logic [TAG_W-1:0] evTag_q;
  logic [PC_W-1:0]  redirPc_q;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evTag_q   <= '0;
      redirPc_q <= '0;
    end else if (strobe.capture) begin
      evTag_q   <= resTag;
      redirPc_q <= resActTaken ? resTarget : (resPc + PC_W'(4));
    end
  end

  assign redirectValid = strobe.squash;
  assign redirectPc    = redirPc_q;

  specTagBuf #(.N(DEC_N), .TAG_W(TAG_W)) decBuf_i (
    .clk(clk), .rstN(rstN),
    .allocValid(decAllocValid), .allocIdx(decAllocIdx),
    .allocSpec(decAllocSpec), .allocTag(decAllocTag),
    .freeValid(decFreeValid), .freeIdx(decFreeIdx),
    .squash(strobe.squash), .commit(strobe.commit), .evTag(evTag_q),
    .validVec(decValid), .killVec(decKill)
  );

  specTagBuf #(.N(DSP_N), .TAG_W(TAG_W)) dspBuf_i (
    .clk(clk), .rstN(rstN),
    .allocValid(dspAllocValid), .allocIdx(dspAllocIdx),
    .allocSpec(dspAllocSpec), .allocTag(dspAllocTag),
    .freeValid(dspFreeValid), .freeIdx(dspFreeIdx),
    .squash(strobe.squash), .commit(strobe.commit), .evTag(evTag_q),
    .validVec(dspValid), .killVec(dspKill)
  );

  specTagBuf #(.N(RS_N), .TAG_W(TAG_W)) rsBuf_i (
    .clk(clk), .rstN(rstN),
    .allocValid(rsAllocValid), .allocIdx(rsAllocIdx),
    .allocSpec(rsAllocSpec), .allocTag(rsAllocTag),
    .freeValid(rsFreeValid), .freeIdx(rsFreeIdx),
    .squash(strobe.squash), .commit(strobe.commit), .evTag(evTag_q),
    .validVec(rsValid), .killVec(rsKill)
  );
endmodule

// File: rtl/brRecoveryCtl.sv
module brRecoveryCtl
  import brRecPkg::*;
#(
  parameter int TAG_W = 2,
  parameter int PC_W  = 32,
  parameter int DEC_N = 4,
  parameter int DSP_N = 4,
  parameter int RS_N  = 8,
  localparam int DEC_IW = (DEC_N > 1) ? $clog2(DEC_N) : 1,
  localparam int DSP_IW = (DSP_N > 1) ? $clog2(DSP_N) : 1,
  localparam int RS_IW  = (RS_N > 1) ? $clog2(RS_N) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              brFetchReq,
  output logic              brFetchGrant,
  output logic [TAG_W-1:0]  brFetchTag,
  output logic              allocStall,
  input  logic              resValid,
  input  logic [TAG_W-1:0]  resTag,
  input  logic              resPredTaken,
  input  logic              resActTaken,
  input  logic [PC_W-1:0]   resTarget,
  input  logic [PC_W-1:0]   resPc,
  output logic              redirectValid,
  output logic [PC_W-1:0]   redirectPc,
  input  logic              decAllocValid,
  input  logic [DEC_IW-1:0] decAllocIdx,
  input  logic              decAllocSpec,
  input  logic [TAG_W-1:0]  decAllocTag,
  input  logic              decFreeValid,
  input  logic [DEC_IW-1:0] decFreeIdx,
  output logic [DEC_N-1:0]  decValid,
  output logic [DEC_N-1:0]  decKill,
  input  logic              dspAllocValid,
  input  logic [DSP_IW-1:0] dspAllocIdx,
  input  logic              dspAllocSpec,
  input  logic [TAG_W-1:0]  dspAllocTag,
  input  logic              dspFreeValid,
  input  logic [DSP_IW-1:0] dspFreeIdx,
  output logic [DSP_N-1:0]  dspValid,
  output logic [DSP_N-1:0]  dspKill,
  input  logic              rsAllocValid,
  input  logic [RS_IW-1:0]  rsAllocIdx,
  input  logic              rsAllocSpec,
  input  logic [TAG_W-1:0]  rsAllocTag,
  input  logic              rsFreeValid,
  input  logic [RS_IW-1:0]  rsFreeIdx,
  output logic [RS_N-1:0]   rsValid,
  output logic [RS_N-1:0]   rsKill
);
  recStrobe_t strobe;

  brRecCtl #(.TAG_W(TAG_W)) ctl_i (
    .clk(clk), .rstN(rstN),
    .brFetchReq(brFetchReq), .brFetchGrant(brFetchGrant),
    .brFetchTag(brFetchTag), .allocStall(allocStall),
    .resValid(resValid), .resTag(resTag),
    .resPredTaken(resPredTaken), .resActTaken(resActTaken),
    .strobe(strobe)
  );

  brRecData #(
    .TAG_W(TAG_W), .PC_W(PC_W), .DEC_N(DEC_N), .DSP_N(DSP_N), .RS_N(RS_N)
  ) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .resTag(resTag), .resActTaken(resActTaken),
    .resTarget(resTarget), .resPc(resPc),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .decAllocValid(decAllocValid), .decAllocIdx(decAllocIdx),
    .decAllocSpec(decAllocSpec), .decAllocTag(decAllocTag),
    .decFreeValid(decFreeValid), .decFreeIdx(decFreeIdx),
    .decValid(decValid), .decKill(decKill),
    .dspAllocValid(dspAllocValid), .dspAllocIdx(dspAllocIdx),
    .dspAllocSpec(dspAllocSpec), .dspAllocTag(dspAllocTag),
    .dspFreeValid(dspFreeValid), .dspFreeIdx(dspFreeIdx),
    .dspValid(dspValid), .dspKill(dspKill),
    .rsAllocValid(rsAllocValid), .rsAllocIdx(rsAllocIdx),
    .rsAllocSpec(rsAllocSpec), .rsAllocTag(rsAllocTag),
    .rsFreeValid(rsFreeValid), .rsFreeIdx(rsFreeIdx),
    .rsValid(rsValid), .rsKill(rsKill)
  );
endmodule

// File: rtl/brRecoveryCtl_chk.sv
module brRecoveryCtl_chk #(
  parameter int DEC_N = 4,
  parameter int DSP_N = 4,
  parameter int RS_N  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             brFetchGrant,
  input logic             allocStall,
  input logic             resValid,
  input logic             resPredTaken,
  input logic             resActTaken,
  input logic             redirectValid,
  input logic [DEC_N-1:0] decKill,
  input logic [DSP_N-1:0] dspKill,
  input logic [RS_N-1:0]  rsKill
);
  // R3
  redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> !redirectValid);

  // R3
  kill_needs_redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|decKill) || (|dspKill) || (|rsKill)) |-> redirectValid);

  // R3
  redirect_after_res_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> $past(resValid));

  // R6
  redirect_only_on_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> $past(resPredTaken != resActTaken));

  // R8
  grant_stall_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(brFetchGrant && allocStall));

  // R8
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    brFetchGrant |=> !brFetchGrant);
endmodule

bind brRecoveryCtl brRecoveryCtl_chk #(
  .DEC_N(DEC_N), .DSP_N(DSP_N), .RS_N(RS_N)
) chk_i (.*);

// File: tb/brRecoveryCtl_tb_top.sv
`timescale 1ns/1ps
module brRecoveryCtl_tb_top;
  localparam int TAG_W = 2;
  localparam int PC_W  = 32;
  localparam int MAXN  = 8;
  localparam int WATCHDOG_CYC = 200000;

  int bufN [3] = '{4, 4, 8};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic             brFetchReq, brFetchGrant, allocStall;
  logic [TAG_W-1:0] brFetchTag;
  logic             resValid, resPredTaken, resActTaken;
  logic [TAG_W-1:0] resTag;
  logic [PC_W-1:0]  resTarget, resPc, redirectPc;
  logic             redirectValid;
  logic             decAllocValid, decAllocSpec, decFreeValid;
  logic [1:0]       decAllocIdx, decFreeIdx;
  logic [TAG_W-1:0] decAllocTag;
  logic [3:0]       decValid, decKill;
  logic             dspAllocValid, dspAllocSpec, dspFreeValid;
  logic [1:0]       dspAllocIdx, dspFreeIdx;
  logic [TAG_W-1:0] dspAllocTag;
  logic [3:0]       dspValid, dspKill;
  logic             rsAllocValid, rsAllocSpec, rsFreeValid;
  logic [2:0]       rsAllocIdx, rsFreeIdx;
  logic [TAG_W-1:0] rsAllocTag;
  logic [7:0]       rsValid, rsKill;

  brRecoveryCtl dut_i (.*);

  logic [7:0] actValid [3];
  logic [7:0] actKill  [3];
  assign actValid[0] = {4'b0, decValid};
  assign actValid[1] = {4'b0, dspValid};
  assign actValid[2] = rsValid;
  assign actKill[0]  = {4'b0, decKill};
  assign actKill[1]  = {4'b0, dspKill};
  assign actKill[2]  = rsKill;

  // stimulus
  logic             fReq, rV, rPred, rAct;
  logic [TAG_W-1:0] rTag;
  logic [PC_W-1:0]  rTgt, rPc;
  logic             aV [3], aS [3], fV [3];
  logic [TAG_W-1:0] aT [3];
  int               aI [3], fI [3];

  // reference model
  logic             mV [3][MAXN], mS [3][MAXN];
  logic [TAG_W-1:0] mT [3][MAXN];
  logic             mOut, mPend, mMiss, mPAct;
  logic [TAG_W-1:0] mCur, mNext, mPTag;
  logic [PC_W-1:0]  mPPc;

  int nChk = 0, nFail = 0;
  bit done = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    fReq = 0; rV = 0; rPred = 0; rAct = 0; rTag = '0; rTgt = '0; rPc = '0;
    for (int b = 0; b < 3; b++) begin
      aV[b] = 0; aS[b] = 0; aT[b] = '0; aI[b] = 0; fV[b] = 0; fI[b] = 0;
    end
  endtask

  task automatic drive();
    brFetchReq = fReq; resValid = rV; resTag = rTag;
    resPredTaken = rPred; resActTaken = rAct; resTarget = rTgt; resPc = rPc;
    decAllocValid = aV[0]; decAllocIdx = 2'(aI[0]); decAllocSpec = aS[0];
    decAllocTag = aT[0]; decFreeValid = fV[0]; decFreeIdx = 2'(fI[0]);
    dspAllocValid = aV[1]; dspAllocIdx = 2'(aI[1]); dspAllocSpec = aS[1];
    dspAllocTag = aT[1]; dspFreeValid = fV[1]; dspFreeIdx = 2'(fI[1]);
    rsAllocValid = aV[2]; rsAllocIdx = 3'(aI[2]); rsAllocSpec = aS[2];
    rsAllocTag = aT[2]; rsFreeValid = fV[2]; rsFreeIdx = 3'(fI[2]);
  endtask

  // One clock: drive, check against model, advance model.
  task automatic cycle();
    logic [7:0] eK [3];
    logic [7:0] eV;
    logic sq, cm, hit;
    @(negedge clk);
    drive();
    #1;
    sq = mPend && mMiss;
    cm = mPend && !mMiss;
    chk("R7 grant", brFetchGrant, fReq && !mOut);
    chk("R8 stall", allocStall, fReq && mOut);
    if (fReq && !mOut) chk("R7 tag", brFetchTag, mNext);
    chk(sq ? "R3 redirect pulse" : "R6 no redirect", redirectValid, sq);
    if (sq) chk(mPAct ? "R1 target" : "R2 sequential", redirectPc, mPPc);
    for (int b = 0; b < 3; b++) begin
      eK[b] = '0; eV = '0;
      for (int i = 0; i < bufN[b]; i++) begin
        eV[i] = mV[b][i];
        eK[b][i] = sq && ((mV[b][i] && mS[b][i] && mT[b][i] == mPTag) ||
                          (aV[b] && aI[b] == i && aS[b] && aT[b] == mPTag));
      end
      chk(sq ? "R4 kill" : "R6 kill", actKill[b], eK[b]);
      chk("R4 valid", actValid[b], eV);
    end
    for (int b = 0; b < 3; b++) begin
      for (int i = 0; i < bufN[b]; i++) begin
        if (fV[b] && fI[b] == i) mV[b][i] = 0;
        if (aV[b] && aI[b] == i) begin
          mV[b][i] = 1; mS[b][i] = aS[b]; mT[b][i] = aT[b];
        end
        if (eK[b][i]) mV[b][i] = 0;
        if (cm && mT[b][i] == mPTag) mS[b][i] = 0;
      end
    end
    hit = rV && mOut && !mPend && rTag == mCur;
    if (mPend) mOut = 0;
    else if (fReq && !mOut) begin
      mOut = 1; mCur = mNext; mNext = mNext + 1'b1;
    end
    mPend = hit;
    if (hit) begin
      mMiss = rPred != rAct; mPTag = rTag; mPAct = rAct;
      mPPc = rAct ? rTgt : rPc + 32'd4;
    end
  endtask

  task automatic resolve(logic pred, logic act, logic [PC_W-1:0] tgt, logic [PC_W-1:0] pc);
    idle(); rV = 1; rTag = mCur; rPred = pred; rAct = act; rTgt = tgt; rPc = pc;
    cycle();
  endtask

  task automatic grantOne();
    idle(); fReq = 1; cycle();
  endtask

  initial begin
    for (int b = 0; b < 3; b++)
      for (int i = 0; i < MAXN; i++) begin mV[b][i] = 0; mS[b][i] = 0; mT[b][i] = '0; end
    mOut = 0; mPend = 0; mMiss = 0; mPAct = 0; mCur = '0; mNext = '0; mPTag = '0; mPPc = '0;
    idle(); drive();
    void'($urandom(32'h0BAD_5EED));
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R10 reset state
    #1;
    chk("R10 dec empty", decValid, 0);
    chk("R10 dsp empty", dspValid, 0);
    chk("R10 rs empty", rsValid, 0);
    chk("R10 no redirect", redirectValid, 0);
    chk("R10 no kill", {decKill, dspKill, rsKill}, 0);
    chk("R10 first tag", brFetchTag, 0);

    // R7 first grant, R8 second request stalls
    grantOne();
    chk("R7 first grant", brFetchGrant, 1);
    grantOne();
    chk("R8 held off", allocStall, 1);

    // R1 and R5: wrong-path entries in three stages, one written in recovery cycle
    idle();
    aV[0] = 1; aI[0] = 1; aS[0] = 1; aT[0] = mCur;
    aV[1] = 1; aI[1] = 2; aS[1] = 0; aT[1] = mCur;
    aV[2] = 1; aI[2] = 5; aS[2] = 1; aT[2] = mCur;
    cycle();
    resolve(0, 1, 32'h0000_1000, 32'h0000_0200);
    idle(); fReq = 1;
    aV[2] = 1; aI[2] = 6; aS[2] = 1; aT[2] = mPTag;
    cycle();
    chk("R1 redirect", redirectValid, 1);
    chk("R1 target", redirectPc, 32'h0000_1000);
    chk("R5 same-cycle kill", rsKill, 8'h60);
    chk("R4 dec kill", decKill, 4'h2);
    chk("R8 stalled in pulse", allocStall, 1);
    idle(); cycle();
    chk("R5 squashed alloc gone", rsValid[6], 0);
    chk("R4 nonspec kept", dspValid[2], 1);

    // R2 taken -> not taken
    grantOne();
    resolve(1, 0, 32'h0000_4000, 32'h0000_0300);
    idle(); cycle();
    chk("R2 redirect", redirectValid, 1);
    chk("R2 sequential", redirectPc, 32'h0000_0304);

    // R9 stray tag while outstanding, then resolution with none outstanding
    grantOne();
    idle(); rV = 1; rTag = mCur + 1'b1; rPred = 0; rAct = 1; cycle();
    idle(); cycle();
    chk("R9 stray tag ignored", redirectValid, 0);
    resolve(1, 1, 0, 0);
    idle(); cycle();
    idle(); rV = 1; rTag = mCur; rPred = 0; rAct = 1; cycle();
    idle(); cycle();
    chk("R9 none outstanding", redirectValid, 0);

    // R6 commit then reuse of the same tag value after wrap
    idle(); fReq = 1;
    cycle();
    idle(); aV[0] = 1; aI[0] = 3; aS[0] = 1; aT[0] = mCur; cycle();
    resolve(1, 1, 0, 32'h10);
    idle(); cycle();
    for (int k = 0; k < (1 << TAG_W) - 1; k++) begin
      grantOne();
      resolve(0, 0, 0, 32'h20);
      idle(); cycle();
    end
    grantOne();
    resolve(0, 1, 32'h800, 32'h30);
    idle(); cycle();
    chk("R6 redirect on reused tag", redirectValid, 1);
    chk("R6 committed entry kept", decKill[3], 0);
    idle(); cycle();
    chk("R6 committed entry valid", decValid[3], 1);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      idle();
      fReq = ($urandom % 3) == 0;
      if (mOut && !mPend && ($urandom % 4) == 0) begin
        rV = 1;
        rTag = (($urandom % 8) == 0) ? TAG_W'($urandom) : mCur;
        rPred = 1'($urandom); rAct = 1'($urandom);
        rTgt = $urandom; rPc = $urandom;
      end else if (($urandom % 16) == 0) begin
        rV = 1; rTag = TAG_W'($urandom); rPred = 0; rAct = 1;
        rTgt = $urandom; rPc = $urandom;
      end
      for (int b = 0; b < 3; b++) begin
        if (($urandom % 2) == 0) begin
          aI[b] = int'($urandom % bufN[b]);
          aV[b] = !mV[b][aI[b]];
          aS[b] = 1'($urandom);
          aT[b] = (($urandom % 4) == 0) ? TAG_W'($urandom) : (mPend ? mPTag : mCur);
        end
        if (($urandom % 4) == 0) begin
          fI[b] = int'($urandom % bufN[b]);
          fV[b] = !(aV[b] && aI[b] == fI[b]);
        end
      end
      cycle();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end
endmodule